// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block is the word-acceptance stage of one ARINC 429 receive channel. A deserializer upstream hands it complete 32-bit words with a one-cycle valid strobe. The block decides whether to keep each word and stores the kept words in a 32-entry first-in first-out buffer. The host drains that buffer through a show-ahead read port. A word can be rejected for three reasons: a failed odd-parity check, a mismatch on the two decoder bits, or a missing external label hit. The label byte can be stored as received or bit-reversed.

The block also serves the bit-level front end of the channel. It produces a bit-rate enable pulse derived from the block clock, which divides by 10 for high speed or by 80 for low speed. It also picks the serial receive bit from either the line or the local transmit loopback.

All channel settings come from a 16-bit control word input. A one-cycle control-write pulse empties the buffer. A FLAG output reports either "buffer holds data" or "buffer is full", depending on one control bit.

Top module: `a429_word_filter`

## Requirements
- R1: With cfg_i[0]=0, bit_en_o pulses high for one clock once every 10 clocks. With cfg_i[0]=1, it pulses once every 80 clocks.
- R2: With cfg_i[1]=0, flag_o equals "buffer not empty". With cfg_i[1]=1, flag_o is high only while the buffer holds 32 words.
- R3: A clock edge with cfg_i[3]=1 or cfg_wr_i=1 leaves the buffer empty after that edge. No word presented while cfg_i[3]=1 is stored.
- R4: With cfg_i[4]=1, a word is stored only if the 32 bits of word_i contain an odd number of ones. With cfg_i[4]=0, parity has no effect.
- R5: rx_bit_o equals loop_rx_i when cfg_i[5]=0, and line_rx_i when cfg_i[5]=1.
- R6: With cfg_i[6]=1, a word is stored only if word_i[9] equals cfg_i[7] and word_i[8] equals cfg_i[8]. With cfg_i[6]=0, those bits are not compared.
- R7: With cfg_i[9]=1, the stored word equals word_i. With cfg_i[9]=0, stored bit k equals word_i[7-k] for k in 0..7, and bits 31..8 are unchanged.
- R8: With cfg_i[2]=1, a word is stored only if lbl_hit_i is high in its valid cycle. With cfg_i[2]=0, lbl_hit_i has no effect.
- R9: The buffer holds 32 words and returns them oldest first. rd_data_o shows the oldest word, and rd_i pops it when the buffer is not empty. full_o is high at 32 words and empty_o at 0 words.
- R10: A word that arrives while the buffer is full is discarded and the stored words are unchanged, even if rd_i is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the divided rate source) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 16 | Channel control word |
| cfg_wr_i | input | 1 | Control-write pulse, empties the buffer |
| line_rx_i | input | 1 | Serial bit from the line receiver |
| loop_rx_i | input | 1 | Serial bit from the local transmitter |
| rx_bit_o | output | 1 | Selected serial receive bit |
| bit_en_o | output | 1 | Bit-rate enable pulse |
| word_i | input | 32 | Deserialized word |
| word_vld_i | input | 1 | word_i is valid this cycle |
| lbl_hit_i | input | 1 | External label-table hit for word_i |
| rd_i | input | 1 | Pop the oldest buffered word |
| rd_data_o | output | 32 | Oldest buffered word |
| empty_o | output | 1 | Buffer holds no word |
| full_o | output | 1 | Buffer holds 32 words |
| flag_o | output | 1 | Host flag, meaning set by cfg_i[1] |

## Verification
The bench builds the block with its default parameters: a 32-word buffer and rate divisors of 10 and 80. With these values, a full fill-and-drain and the discard of the 33rd word take under a hundred cycles. Both rate periods can be measured directly on the bit enable. A vector table covers every acceptance condition on its own and in combination, including label reversal together with parity.

// File: rtl/a429_filt_pkg.sv
package a429_filt_pkg;

    typedef struct packed {
        logic rate_slow;
        logic flag_full;
        logic lbl_en;
        logic rx_rst;
        logic par_en;
        logic line_sel;
        logic dec_en;
        logic dec_b10;
        logic dec_b9;
        logic lbl_keep;
    } ctl_t;

    function automatic ctl_t unpack_ctl(input logic [15:0] w);
        ctl_t c;
        c.rate_slow = w[0];
        c.flag_full = w[1];
        c.lbl_en    = w[2];
        c.rx_rst    = w[3];
        c.par_en    = w[4];
        c.line_sel  = w[5];
        c.dec_en    = w[6];
        c.dec_b10   = w[7];
        c.dec_b9    = w[8];
        c.lbl_keep  = w[9];
        return c;
    endfunction

endpackage

// File: rtl/a429_rate_div.sv
module a429_rate_div #(
    parameter int FAST_DIV = 10,
    parameter int SLOW_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic slow_i,
    output logic en_o
);
    localparam int CW = $clog2(SLOW_DIV > FAST_DIV ? SLOW_DIV : FAST_DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = slow_i ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
        st_d = st_q;
        en_o = (st_q.cnt >= lim);
        if (clr_i || en_o) st_d.cnt = '0;
        else               st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/a429_accept.sv
module a429_accept
    import a429_filt_pkg::*;
#(
    parameter int W     = 32,
    parameter int LBL_W = 8
) (
    input  ctl_t         ctl_i,
    input  logic [W-1:0] word_i,
    input  logic         hit_i,
    output logic         ok_o,
    output logic [W-1:0] store_o
);
    logic [LBL_W-1:0] lbl_rev;
    logic par_ok, dec_ok, lbl_ok;

    for (genvar k = 0; k < LBL_W; k++) begin : g_rev
        assign lbl_rev[k] = word_i[LBL_W-1-k];
    end

    always_comb begin
        par_ok  = !ctl_i.par_en || (^word_i);
        dec_ok  = !ctl_i.dec_en ||
                  ((word_i[LBL_W+1] == ctl_i.dec_b10) && (word_i[LBL_W] == ctl_i.dec_b9));
        lbl_ok  = !ctl_i.lbl_en || hit_i;
        ok_o    = par_ok && dec_ok && lbl_ok;
        store_o = ctl_i.lbl_keep ? word_i : {word_i[W-1:LBL_W], lbl_rev};
    end
endmodule

// File: rtl/a429_fifo.sv
module a429_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         rd_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        empty_o = (st_q.cnt == '0);
        full_o  = (st_q.cnt == CW'(DEPTH));
        do_wr   = wr_i && !full_o && !clr_i;
        do_rd   = rd_i && !empty_o && !clr_i;
        rdata_o = mem[st_q.rp];
        st_d    = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (do_wr) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            if (do_rd) st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wp] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/a429_word_filter.sv
module a429_word_filter
    import a429_filt_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int W        = 32,
    parameter int FAST_DIV = 10,
    parameter int SLOW_DIV = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [15:0]  cfg_i,
    input  logic         cfg_wr_i,
    input  logic         line_rx_i,
    input  logic         loop_rx_i,
    output logic         rx_bit_o,
    output logic         bit_en_o,
    input  logic [W-1:0] word_i,
    input  logic         word_vld_i,
    input  logic         lbl_hit_i,
    input  logic         rd_i,
    output logic [W-1:0] rd_data_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         flag_o
);
    ctl_t         ctl;
    logic         ok, clr, wr;
    logic [W-1:0] store;

    always_comb begin
        ctl      = unpack_ctl(cfg_i);
        clr      = cfg_wr_i || ctl.rx_rst;
        wr       = word_vld_i && ok;
        rx_bit_o = ctl.line_sel ? line_rx_i : loop_rx_i;
        flag_o   = ctl.flag_full ? full_o : !empty_o;
    end

    a429_rate_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .clr_i(ctl.rx_rst),
        .slow_i(ctl.rate_slow), .en_o(bit_en_o)
    );

    a429_accept #(.W(W)) u_acc (
        .ctl_i(ctl), .word_i(word_i), .hit_i(lbl_hit_i),
        .ok_o(ok), .store_o(store)
    );

    a429_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_i(wr), .wdata_i(store),
        .rd_i(rd_i), .rdata_o(rd_data_o), .empty_o(empty_o), .full_o(full_o)
    );
endmodule

module a429_word_filter_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [15:0]  cfg_i,
    input logic         cfg_wr_i,
    input logic         bit_en_o,
    input logic [W-1:0] word_i,
    input logic         word_vld_i,
    input logic         rd_i,
    input logic [W-1:0] rd_data_o,
    input logic         empty_o,
    input logic         full_o,
    input logic         flag_o
);
    // R1
    rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en_o |=> !bit_en_o);

    // R2
    flag_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> flag_o);

    // R3
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[3] || cfg_wr_i) |=> empty_o);

    // R4
    parity_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && word_vld_i && cfg_i[4] && !(^word_i)) |=> empty_o);

    // R6
    decoder_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && word_vld_i && cfg_i[6] && (word_i[9] != cfg_i[7])) |=> empty_o);

    // R9
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !empty_o);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && word_vld_i && !rd_i && !cfg_i[3] && !cfg_wr_i)
        |=> (full_o && $stable(rd_data_o)));
endmodule

bind a429_word_filter a429_word_filter_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .cfg_wr_i(cfg_wr_i),
    .bit_en_o(bit_en_o), .word_i(word_i), .word_vld_i(word_vld_i),
    .rd_i(rd_i), .rd_data_o(rd_data_o), .empty_o(empty_o),
    .full_o(full_o), .flag_o(flag_o)
);

// File: tb/a429_word_filter_test.sv
module a429_word_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_i = 16'h0220;
    logic        cfg_wr_i = 1'b0;
    logic        line_rx_i = 1'b0;
    logic        loop_rx_i = 1'b0;
    logic        rx_bit_o, bit_en_o;
    logic [31:0] word_i = '0;
    logic        word_vld_i = 1'b0;
    logic        lbl_hit_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        empty_o, full_o, flag_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    a429_word_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .cfg_wr_i(cfg_wr_i),
        .line_rx_i(line_rx_i), .loop_rx_i(loop_rx_i), .rx_bit_o(rx_bit_o),
        .bit_en_o(bit_en_o), .word_i(word_i), .word_vld_i(word_vld_i),
        .lbl_hit_i(lbl_hit_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
        .empty_o(empty_o), .full_o(full_o), .flag_o(flag_o)
    );

    // {cfg[15:0], word[31:0], hit, expect_stored}
    localparam int NV = 13;
    localparam logic [49:0] VEC [NV] = '{
        {16'h0220, 32'h0000_0003, 1'b0, 1'b1},  // R4 parity off, even word kept
        {16'h0230, 32'h0000_0003, 1'b0, 1'b0},  // R4 even rejected
        {16'h0230, 32'h0000_0001, 1'b0, 1'b1},  // R4 odd kept
        {16'h0224, 32'h0000_0001, 1'b0, 1'b0},  // R8 no hit rejected
        {16'h0224, 32'h0000_0001, 1'b1, 1'b1},  // R8 hit kept
        {16'h0220, 32'h0000_0001, 1'b0, 1'b1},  // R8 hit ignored
        {16'h03E0, 32'h0000_0301, 1'b0, 1'b1},  // R6 match 1/1
        {16'h03E0, 32'h0000_0201, 1'b0, 1'b0},  // R6 bit9 mismatch
        {16'h02E0, 32'h0000_0201, 1'b0, 1'b1},  // R6 match 1/0
        {16'h02E0, 32'h0000_0101, 1'b0, 1'b0},  // R6 bit10 mismatch
        {16'h0020, 32'hABCD_EF0E, 1'b0, 1'b1},  // R7 reversed
        {16'h0030, 32'h8000_0001, 1'b0, 1'b0},  // R4 with reversal, even
        {16'h0030, 32'h8000_0003, 1'b0, 1'b1}   // R7 + R4 odd, reversed
    };

    function automatic logic [31:0] model_store(input logic [15:0] c, input logic [31:0] w);
        logic [31:0] r = w;
        if (!c[9]) for (int k = 0; k < 8; k++) r[k] = w[7-k];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk); word_i = w; word_vld_i = 1'b1;
        @(negedge clk); word_vld_i = 1'b0;
    endtask

    task automatic clear_buf();
        @(negedge clk); cfg_wr_i = 1'b1;
        @(negedge clk); cfg_wr_i = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rd_i = 1'b1;
        @(negedge clk); rd_i = 1'b0;
    endtask

    task automatic rate_period(output int p);
        p = 0;
        while (!bit_en_o) @(negedge clk);
        @(negedge clk); p = 1;
        while (!bit_en_o) begin @(negedge clk); p++; end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset empty", 32'(empty_o), 32'd1);
        check("R9 reset full", 32'(full_o), 32'd0);
        check("R2 reset flag", 32'(flag_o), 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); cfg_i = VEC[i][49:34]; lbl_hit_i = VEC[i][1];
            clear_buf();
            push(VEC[i][33:2]);
            check("R4/R6/R7/R8 accept", 32'(!empty_o), 32'(VEC[i][0]));
            if (VEC[i][0]) check("R7 stored", rd_data_o, model_store(VEC[i][49:34], VEC[i][33:2]));
        end
        lbl_hit_i = 1'b0;

        // R5 serial select
        @(negedge clk); cfg_i = 16'h0220; line_rx_i = 1'b1; loop_rx_i = 1'b0;
        #1 check("R5 line", 32'(rx_bit_o), 32'd1);
        cfg_i = 16'h0200;
        #1 check("R5 loopback", 32'(rx_bit_o), 32'd0);
        cfg_i = 16'h0220;

        // R1 rate
        rate_period(p);
        check("R1 fast period", 32'(p), 32'd10);
        @(negedge clk); cfg_i = 16'h0221;
        rate_period(p); rate_period(p);
        check("R1 slow period", 32'(p), 32'd80);
        @(negedge clk); cfg_i = 16'h0220;

        // R9/R2/R10 fill and drain
        clear_buf();
        check("R3 write clears", 32'(empty_o), 32'd1);
        push(32'h1000_0000);
        check("R2 flag not-empty", 32'(flag_o), 32'd1);
        @(negedge clk); cfg_i = 16'h0222;
        #1 check("R2 flag full-mode low", 32'(flag_o), 32'd0);
        for (int i = 1; i < 32; i++) push(32'h1000_0000 + 32'(i));
        check("R9 full at 32", 32'(full_o), 32'd1);
        check("R2 flag full-mode high", 32'(flag_o), 32'd1);
        push(32'hDEAD_BEEF);
        check("R10 still full", 32'(full_o), 32'd1);
        check("R10 head kept", rd_data_o, 32'h1000_0000);
        // R10 arrival while full with same-cycle read
        @(negedge clk); word_i = 32'hDEAD_BEEF; word_vld_i = 1'b1; rd_i = 1'b1;
        @(negedge clk); word_vld_i = 1'b0; rd_i = 1'b0;
        check("R10 discard with read", 32'(full_o), 32'd0);
        for (int i = 1; i < 32; i++) begin
            check("R9 order", rd_data_o, 32'h1000_0000 + 32'(i));
            pop();
        end
        check("R9 drained", 32'(empty_o), 32'd1);

        // R3 receiver reset
        @(negedge clk); cfg_i = 16'h0220;
        push(32'h0000_0005); push(32'h0000_0006);
        @(negedge clk); cfg_i = 16'h0228;
        @(negedge clk);
        check("R3 reset empties", 32'(empty_o), 32'd1);
        push(32'h0000_0007);
        check("R3 no accept in reset", 32'(empty_o), 32'd1);
        @(negedge clk); cfg_i = 16'h0220;
        push(32'h0000_0009);
        check("R3 accepts after reset", rd_data_o, 32'h0000_0009);

        finish_run();
    end
endmodule